// File: doc/BRIEF.md
# Multichannel ADC Conversion-Sequence Controller

This block handles the digital control and readout for a four-channel converter that samples all of its channels at once. A rising edge on the convert-start input captures a channel set. That set comes either from four external select pins or from a small register written over a 4-bit data bus. The block then converts each selected channel in turn, lowest index first. Each conversion takes a fixed, parameterised number of clock cycles. The converted sample for the current channel is supplied on an input port, and the block stores it when that channel's last conversion cycle ends.

A host reads the results over a chip-select/read strobe pair. Each completed read moves a read pointer to the next stored result, and the pointer wraps once the last selected channel has been read. A busy output covers the whole conversion sequence. A first-result flag marks when the pointer addresses the first result register. The data outputs are modelled as a value plus an output-enable signal. All strobes are sampled on the system clock.

Top module: `adc_seq_ctrl`

## Requirements
- R1: A rising edge of `conv_start` while `busy` is low is accepted, and `busy` is high from the next clock cycle.
- R2: For an accepted start with N channels selected (N > 0), `busy` stays high for exactly N × CONV_CYCLES cycles.
- R3: The channel set is captured at the accepted start edge. Bit i selects channel i. It comes from `hw_sel` when `sw_mode` is 0 and from the channel-select register when `sw_mode` is 1.
- R4: A rising edge of `wr_n` while `cs_n` is 0 and `rd_n` is 1 loads `db_in` into the channel-select register. A `wr_n` edge while `cs_n` is 1 leaves the register unchanged.
- R5: `dout_oe` is 1 only while `cs_n` is 0, `rd_n` is 0 and `wr_n` is 1, and is 0 at all other times.
- R6: `first_data` is 1 exactly when the read pointer addresses result register 1, the first result of the sequence.
- R7: Results are stored in ascending channel order in consecutive registers. Each result equals `sample_in` in the last conversion cycle of its channel, and `conv_ch` shows the channel being converted.
- R8: A rising edge of `rd_n` while `cs_n` is 0 advances the pointer to the next result. After the last selected channel the pointer returns to register 1.
- R9: An accepted start returns the read pointer to register 1.
- R10: A `conv_start` edge that arrives while `busy` is high has no effect on the running sequence or on its length.
- R11: If the captured channel set is zero, `busy` is high for one cycle, no result is written, and reads leave the pointer on register 1.
- R12: After reset, `busy` is 0, `first_data` is 1, `dout_oe` is 0 and the channel-select register holds 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| conv_start | input | 1 | Convert-start strobe; the rising edge starts a sequence |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| hw_sel | input | NUM_CH | Channel set supplied on pins |
| sw_mode | input | 1 | 0: use pin channel set, 1: use register channel set |
| db_in | input | NUM_CH | Data bus input written to the channel-select register |
| sample_in | input | DATA_W | Converted sample for the channel on `conv_ch` |
| conv_ch | output | CH_W | Index of the channel being converted |
| busy | output | 1 | High while a conversion sequence runs |
| first_data | output | 1 | High when the read pointer is on result register 1 |
| dout | output | DATA_W | Result addressed by the read pointer |
| dout_oe | output | 1 | Output enable for `dout` (low means high-impedance) |

## Verification
The hardest situation to reach from the ports is a convert-start edge that arrives in the middle of a running sequence. The stimulus raises the strobe a few cycles into a four-channel run, lowers it, and then measures the full busy window, which must still last four conversion periods. A second awkward case is a write with chip select high that must be dropped. It leaves no direct trace, so the bench exposes it by starting a register-sourced sequence afterwards and counting busy cycles, which reveals the set that was actually held. Pointer wrap is checked by reading one result past the last selected channel and observing the first-result flag.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    typedef enum logic [1:0] {
        ENG_IDLE  = 2'd0,
        ENG_PULSE = 2'd1,
        ENG_CONV  = 2'd2
    } eng_state_e;

    // Lowest set bit index of a mask (0 when mask is empty)
    function automatic int unsigned lowest_idx(input logic [15:0] m);
        int unsigned r;
        r = 0;
        for (int i = 15; i >= 0; i--) begin
            if (m[i]) r = i;
        end
        return r;
    endfunction

endpackage

// File: rtl/adc_seq_edge.sv
module adc_seq_edge #(
    parameter int           W       = 3,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    output logic [W-1:0] rise
);
    for (genvar g = 0; g < W; g++) begin : g_bit
        logic prev;
        always_ff @(posedge clk) begin
            if (rst) prev <= RST_VAL[g];
            else     prev <= din[g];
        end
        assign rise[g] = din[g] & ~prev;
    end
endmodule

// File: rtl/adc_seq_engine.sv
module adc_seq_engine
    import adc_seq_pkg::*;
#(
    parameter int NUM_CH      = 4,
    parameter int DATA_W      = 12,
    parameter int CONV_CYCLES = 8,
    localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
    localparam int CNT_W = $clog2(NUM_CH + 1),
    localparam int CYC_W = $clog2(CONV_CYCLES + 1)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     start_edge,
    input  logic [NUM_CH-1:0]        sel_mask,
    input  logic [DATA_W-1:0]        sample_in,
    output logic                     busy,
    output logic                     accept,
    output logic [CH_W-1:0]          conv_ch,
    output logic [CNT_W-1:0]         nsel,
    output logic [NUM_CH*DATA_W-1:0] results
);
    eng_state_e        state;
    logic [NUM_CH-1:0] remain;
    logic [CYC_W-1:0]  cyc;
    logic [CNT_W-1:0]  wr_idx;

    int unsigned       cur_idx;
    logic [NUM_CH-1:0] cur_onehot;
    logic [NUM_CH-1:0] remain_next;
    logic              last_cyc;

    always_comb begin
        cur_idx     = lowest_idx(16'(remain));
        cur_onehot  = NUM_CH'(1) << cur_idx;
        remain_next = remain & ~cur_onehot;
        last_cyc    = (cyc == CYC_W'(CONV_CYCLES - 1));
    end

    assign accept  = start_edge && (state == ENG_IDLE);
    assign busy    = (state != ENG_IDLE);
    assign conv_ch = CH_W'(cur_idx);

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ENG_IDLE;
            remain <= '0;
            cyc    <= '0;
            wr_idx <= '0;
            nsel   <= '0;
        end else begin
            case (state)
                ENG_IDLE: begin
                    if (accept) begin
                        remain <= sel_mask;
                        cyc    <= '0;
                        wr_idx <= '0;
                        nsel   <= CNT_W'($countones(sel_mask));
                        state  <= (sel_mask == '0) ? ENG_PULSE : ENG_CONV;
                    end
                end
                ENG_PULSE: state <= ENG_IDLE;
                ENG_CONV: begin
                    if (last_cyc) begin
                        cyc    <= '0;
                        remain <= remain_next;
                        wr_idx <= wr_idx + CNT_W'(1);
                        if (remain_next == '0) state <= ENG_IDLE;
                    end else begin
                        cyc <= cyc + CYC_W'(1);
                    end
                end
                default: state <= ENG_IDLE;
            endcase
        end
    end

    // One result register per slot, written in sequence order
    for (genvar s = 0; s < NUM_CH; s++) begin : g_slot
        logic [DATA_W-1:0] slot_q;
        logic              we;
        assign we = (state == ENG_CONV) && last_cyc && (wr_idx == CNT_W'(s));
        always_ff @(posedge clk) begin
            if (rst)     slot_q <= '0;
            else if (we) slot_q <= sample_in;
        end
        assign results[s*DATA_W +: DATA_W] = slot_q;
    end
endmodule

// File: rtl/adc_seq_readout.sv
module adc_seq_readout #(
    parameter int NUM_CH = 4,
    parameter int DATA_W = 12,
    localparam int CNT_W = $clog2(NUM_CH + 1)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     accept,
    input  logic                     rd_adv,
    input  logic [CNT_W-1:0]         nsel,
    input  logic [NUM_CH*DATA_W-1:0] results,
    output logic                     first_data,
    output logic [DATA_W-1:0]        dout
);
    logic [CNT_W-1:0] ptr;
    logic [CNT_W-1:0] ptr_inc;

    assign ptr_inc = ptr + CNT_W'(1);

    always_ff @(posedge clk) begin
        if (rst || accept) begin
            ptr <= '0;
        end else if (rd_adv) begin
            if (ptr_inc >= nsel) ptr <= '0;
            else                 ptr <= ptr_inc;
        end
    end

    always_comb begin
        dout = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (ptr == CNT_W'(i)) dout = results[i*DATA_W +: DATA_W];
        end
    end

    assign first_data = (ptr == '0);
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
    import adc_seq_pkg::*;
#(
    parameter int NUM_CH      = 4,
    parameter int DATA_W      = 12,
    parameter int CONV_CYCLES = 8,
    localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
    localparam int CNT_W = $clog2(NUM_CH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              conv_start,
    input  logic              cs_n,
    input  logic              rd_n,
    input  logic              wr_n,
    input  logic [NUM_CH-1:0] hw_sel,
    input  logic              sw_mode,
    input  logic [NUM_CH-1:0] db_in,
    input  logic [DATA_W-1:0] sample_in,
    output logic [CH_W-1:0]   conv_ch,
    output logic              busy,
    output logic              first_data,
    output logic [DATA_W-1:0] dout,
    output logic              dout_oe
);
    logic [2:0]               rise;
    logic [NUM_CH-1:0]        chan_reg;
    logic [NUM_CH-1:0]        sel_mask;
    logic                     accept;
    logic [CNT_W-1:0]         nsel;
    logic [NUM_CH*DATA_W-1:0] results;
    logic                     rd_adv;
    logic                     wr_load;

    // bit 2: convert start, bit 1: read strobe, bit 0: write strobe
    adc_seq_edge #(.W(3), .RST_VAL(3'b011)) u_edge (
        .clk  (clk),
        .rst  (rst),
        .din  ({conv_start, rd_n, wr_n}),
        .rise (rise)
    );

    assign wr_load = rise[0] && !cs_n && rd_n;
    assign rd_adv  = rise[1] && !cs_n;

    always_ff @(posedge clk) begin
        if (rst)          chan_reg <= '0;
        else if (wr_load) chan_reg <= db_in;
    end

    assign sel_mask = sw_mode ? chan_reg : hw_sel;

    adc_seq_engine #(
        .NUM_CH(NUM_CH), .DATA_W(DATA_W), .CONV_CYCLES(CONV_CYCLES)
    ) u_engine (
        .clk        (clk),
        .rst        (rst),
        .start_edge (rise[2]),
        .sel_mask   (sel_mask),
        .sample_in  (sample_in),
        .busy       (busy),
        .accept     (accept),
        .conv_ch    (conv_ch),
        .nsel       (nsel),
        .results    (results)
    );

    adc_seq_readout #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) u_readout (
        .clk        (clk),
        .rst        (rst),
        .accept     (accept),
        .rd_adv     (rd_adv),
        .nsel       (nsel),
        .results    (results),
        .first_data (first_data),
        .dout       (dout)
    );

    assign dout_oe = !cs_n && !rd_n && wr_n;
endmodule

// File: rtl/adc_seq_ctrl_chk.sv
module adc_seq_ctrl_chk #(
    parameter int CONV_CYCLES = 8
) (
    input logic clk,
    input logic rst,
    input logic conv_start,
    input logic cs_n,
    input logic rd_n,
    input logic busy,
    input logic first_data,
    input logic dout_oe
);
    logic        start_q;
    logic        busy_q;
    logic [31:0] run_len;
    logic        start_edge;

    assign start_edge = conv_start && !start_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            start_q <= 1'b0;
            busy_q  <= 1'b0;
            run_len <= '0;
        end else begin
            start_q <= conv_start;
            busy_q  <= busy;
            run_len <= busy ? run_len + 32'd1 : 32'd0;
        end
    end

    assert_start_sets_busy_R1: assert property (@(posedge clk) disable iff (rst)
        (start_edge && !busy) |=> busy);

    assert_busy_window_R2: assert property (@(posedge clk) disable iff (rst)
        (busy_q && !busy) |-> (run_len == 32'd1 || (run_len % CONV_CYCLES) == 0));

    assert_oe_gated_R5: assert property (@(posedge clk) disable iff (rst)
        dout_oe |-> (!cs_n && !rd_n));

    assert_start_rewinds_R9: assert property (@(posedge clk) disable iff (rst)
        (start_edge && !busy) |=> first_data);
endmodule

bind adc_seq_ctrl adc_seq_ctrl_chk #(.CONV_CYCLES(CONV_CYCLES)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .conv_start (conv_start),
    .cs_n       (cs_n),
    .rd_n       (rd_n),
    .busy       (busy),
    .first_data (first_data),
    .dout_oe    (dout_oe)
);

// File: tb/adc_seq_ctrl_tb.sv
module adc_seq_ctrl_tb;
    localparam int NUM_CH = 4;
    localparam int DATA_W = 12;
    localparam int CONV   = 8;
    localparam int NVEC   = 6;

    // {sw_mode, hw_sel[3:0], reg value[3:0], seed[3:0]}
    localparam logic [12:0] VEC [NVEC] = '{
        {1'b0, 4'b1111, 4'b0000, 4'd1},
        {1'b0, 4'b0101, 4'b1111, 4'd2},
        {1'b1, 4'b1111, 4'b1010, 4'd3},
        {1'b1, 4'b0000, 4'b1000, 4'd4},
        {1'b0, 4'b0010, 4'b0000, 4'd5},
        {1'b1, 4'b0110, 4'b0111, 4'd6}
    };

    logic clk = 0, rst = 1;
    logic conv_start = 0, cs_n = 1, rd_n = 1, wr_n = 1, sw_mode = 0;
    logic [NUM_CH-1:0] hw_sel = '0, db_in = '0;
    logic [3:0] seed = '0;
    logic [DATA_W-1:0] sample_in;
    logic [1:0] conv_ch;
    logic busy, first_data, dout_oe;
    logic [DATA_W-1:0] dout;
    int checks = 0, fails = 0;

    always #5 clk = ~clk;

    assign sample_in = DATA_W'({seed, 4'h0, 2'b00, conv_ch});

    adc_seq_ctrl #(.NUM_CH(NUM_CH), .DATA_W(DATA_W), .CONV_CYCLES(CONV)) u_dut (
        .clk(clk), .rst(rst), .conv_start(conv_start), .cs_n(cs_n), .rd_n(rd_n),
        .wr_n(wr_n), .hw_sel(hw_sel), .sw_mode(sw_mode), .db_in(db_in),
        .sample_in(sample_in), .conv_ch(conv_ch), .busy(busy),
        .first_data(first_data), .dout(dout), .dout_oe(dout_oe)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic write_reg(input logic [3:0] v, input bit sel);
        @(negedge clk); cs_n = sel ? 1'b0 : 1'b1; db_in = v; wr_n = 0;
        @(negedge clk); wr_n = 1;
        @(negedge clk); cs_n = 1;
    endtask

    task automatic run_conv(input bit glitch, output int len);
        @(negedge clk); conv_start = 1;
        @(negedge clk); conv_start = 0;
        len = 0;
        while (busy && len < 5000) begin
            len++;
            if (glitch && len == 3) conv_start = 1;
            if (glitch && len == 5) conv_start = 0;
            @(negedge clk);
        end
    endtask

    task automatic read_one(output logic fd, output logic oe, output logic [DATA_W-1:0] d);
        @(negedge clk); fd = first_data; cs_n = 0; rd_n = 0;
        @(negedge clk); oe = dout_oe; d = dout; rd_n = 1;
        @(negedge clk); cs_n = 1;
    endtask

    initial begin
        #1000000;
        fails++;
        $display("FAIL watchdog actual=0 expected=1");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        int len;
        logic fd, oe;
        logic [DATA_W-1:0] d;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R12 reset state
        check(busy == 0, "R12 busy", busy, 0);
        check(first_data == 1, "R12 first_data", first_data, 1);
        check(dout_oe == 0, "R12 dout_oe", dout_oe, 0);
        sw_mode = 1;
        run_conv(0, len);
        check(len == 1, "R12 register cleared", len, 1);

        // Vector table: R2 R3 R6 R7 R8
        for (int v = 0; v < NVEC; v++) begin
            logic [3:0] mask;
            int n, k;
            write_reg(VEC[v][7:4], 1);
            sw_mode = VEC[v][12];
            hw_sel  = VEC[v][11:8];
            seed    = VEC[v][3:0];
            mask    = sw_mode ? VEC[v][7:4] : VEC[v][11:8];
            n       = $countones(mask);
            run_conv(0, len);
            check(len == n * CONV, "R2 R3 busy length", len, n * CONV);
            k = 0;
            for (int c = 0; c < NUM_CH; c++) begin
                if (mask[c]) begin
                    read_one(fd, oe, d);
                    check(fd == (k == 0), "R6 first_data", fd, (k == 0));
                    check(oe == 1, "R5 oe during read", oe, 1);
                    check(d == DATA_W'({seed, 6'd0, 2'(c)}), "R7 result value",
                          d, DATA_W'({seed, 6'd0, 2'(c)}));
                    k++;
                end
            end
            @(negedge clk);
            check(first_data == 1, "R8 wrap to first", first_data, 1);
        end

        // R4: write with cs_n high is ignored
        write_reg(4'b0011, 1);
        write_reg(4'b1111, 0);
        sw_mode = 1;
        run_conv(0, len);
        check(len == 2 * CONV, "R4 ignored write", len, 2 * CONV);

        // R10: start while busy is ignored
        sw_mode = 0; hw_sel = 4'b1111;
        run_conv(1, len);
        check(len == 4 * CONV, "R10 start during busy", len, 4 * CONV);

        // R9: accepted start rewinds pointer
        read_one(fd, oe, d);
        @(negedge clk);
        check(first_data == 0, "R8 pointer advanced", first_data, 0);
        hw_sel = 4'b0011;
        run_conv(0, len);
        check(first_data == 1, "R9 rewind on start", first_data, 1);

        // R5: write strobe low blocks the output enable
        @(negedge clk); cs_n = 0; rd_n = 0; wr_n = 0;
        @(negedge clk); check(dout_oe == 0, "R5 oe with wr low", dout_oe, 0);
        cs_n = 1;
        @(negedge clk); rd_n = 1; wr_n = 1;
        @(negedge clk); cs_n = 1; rd_n = 0;
        @(negedge clk); check(dout_oe == 0, "R5 oe with cs high", dout_oe, 0);
        rd_n = 1;

        // R11: empty set, single-cycle busy, pointer stays on first
        hw_sel = 4'b0000; sw_mode = 0;
        run_conv(0, len);
        check(len == 1, "R11 empty busy pulse", len, 1);
        read_one(fd, oe, d);
        @(negedge clk);
        check(first_data == 1, "R11 pointer held", first_data, 1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule